// File: doc/BRIEF.md
# Tagged Direct-Mapped Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2^r entries, selected by the low bits of the branch address. Each entry keeps three things: a valid flag, the complete 32-bit address of the branch that owns the entry, and a two-bit saturating confidence counter.

A fetch stage presents an address on the lookup port and receives a taken or not-taken guess in the same cycle. Later, when the branch resolves, the execute stage presents the same address and the real outcome on the training port. If another branch owns the selected slot, the slot is handed to the new branch. Its counter restarts from weakly-not-taken before the outcome is applied. No other branch shares the history of the old owner.

Top module: `tagged_bht`

## Requirements
- R1: After a synchronous reset, every entry is invalid and a lookup of any address predicts not taken.
- R2: The slot is chosen by address bits [r-1:0]. With r = 0 there is one slot. Two addresses with equal low bits compete for the same slot.
- R3: A lookup hits only when the slot is valid and its stored address equals all 32 bits of the lookup address. A miss predicts not taken.
- R4: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. On a hit, the prediction is taken exactly when the counter is 10 or 11.
- R5: A taken training on a hit increments the counter and saturates at 11.
- R6: A not-taken training on a hit decrements the counter and saturates at 00.
- R7: A training that misses claims the slot. It stores the address, sets valid and starts the counter from 01 before applying the outcome. A taken outcome therefore gives 10 and a not-taken outcome gives 00.
- R8: A training changes only the slot it selects. All other slots keep their contents.
- R9: The lookup is combinational from the stored state. A training in the same cycle becomes visible only after the next rising clock edge.
- R10: While the training strobe is low, no slot changes, whatever the address and outcome inputs carry.
- R11: Reset has priority over a training presented in the same cycle, and that training is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| predAddr | input | 32 | Branch address to look up |
| predTaken | output | 1 | Guess for predAddr: 1 means taken |
| updValid | input | 1 | Training strobe |
| updAddr | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome: 1 means taken |

## Verification
The hardest case is a slot that changes owner while the old owner's counter is saturated. Its visible effect is only that the old owner's predictions fall back to not taken, and that the new owner starts from a fresh counter. To reach it, the stimulus first drives one address to strong taken. It then trains a second address that has the same low bits but a different tag. The first address is then retrained, and the result must show that its counter did not survive. Same-cycle lookup and training of one address is probed separately, sampling before and after the edge.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // write the selected slot this cycle
    logic alloc;  // slot changes owner: restart counter
    logic incr;   // direction of counter step
  } bht_strb_t;

  function automatic ctr_e ctrStep(input ctr_e cur, input logic up);
    ctr_e nxt;
    nxt = cur;
    if (up) begin
      case (cur)
        CTR_SNT: nxt = CTR_WNT;
        CTR_WNT: nxt = CTR_WT;
        CTR_WT:  nxt = CTR_ST;
        default: nxt = CTR_ST;
      endcase
    end else begin
      case (cur)
        CTR_ST:  nxt = CTR_WT;
        CTR_WT:  nxt = CTR_WNT;
        CTR_WNT: nxt = CTR_SNT;
        default: nxt = CTR_SNT;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bht_datapath.sv
module bht_datapath
  import bht_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] predAddr,
  input  logic [ADDR_W-1:0] updAddr,
  input  bht_strb_t         strb,
  output logic              predHit,
  output ctr_e              predCtr,
  output logic              updHit
);

  localparam int ENTRIES = 1 << IDX_BITS;
  localparam int IDX_W   = (IDX_BITS > 0) ? IDX_BITS : 1;

  logic [ADDR_W-1:0] tagQ   [ENTRIES];
  ctr_e              ctrQ   [ENTRIES];
  logic              validQ [ENTRIES];

  logic [IDX_W-1:0] predIdx;
  logic [IDX_W-1:0] updIdx;

  generate
    if (IDX_BITS == 0) begin : g_single
      assign predIdx = '0;
      assign updIdx  = '0;
    end else begin : g_multi
      assign predIdx = predAddr[IDX_W-1:0];
      assign updIdx  = updAddr[IDX_W-1:0];
    end
  endgenerate

  // lookup side
  always_comb begin
    predHit = validQ[predIdx] && (tagQ[predIdx] == predAddr);
    predCtr = ctrQ[predIdx];
  end

  // training side
  ctr_e baseCtr;
  ctr_e nextCtr;
  always_comb begin
    updHit  = validQ[updIdx] && (tagQ[updIdx] == updAddr);
    baseCtr = strb.alloc ? CTR_WNT : ctrQ[updIdx];
    nextCtr = ctrStep(baseCtr, strb.incr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        validQ[e] <= 1'b0;
        ctrQ[e]   <= CTR_WNT;
        tagQ[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strb.wrEn && (updIdx == IDX_W'(e))) begin
          validQ[e] <= 1'b1;
          ctrQ[e]   <= nextCtr;
          tagQ[e]   <= updAddr;
        end
      end
    end
  end

endmodule

// File: rtl/bht_ctrl.sv
module bht_ctrl
  import bht_pkg::*;
(
  input  logic      updValid,
  input  logic      updTaken,
  input  logic      updHit,
  input  logic      predHit,
  input  ctr_e      predCtr,
  output bht_strb_t strb,
  output logic      predTaken
);

  always_comb begin
    strb.wrEn  = updValid;
    strb.alloc = !updHit;
    strb.incr  = updTaken;
  end

  always_comb begin
    predTaken = 1'b0;
    if (predHit) begin
      case (predCtr)
        CTR_WT, CTR_ST: predTaken = 1'b1;
        default:        predTaken = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/tagged_bht.sv
module tagged_bht
  import bht_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] predAddr,
  output logic              predTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken
);

  bht_strb_t strb;
  logic      predHit;
  logic      updHit;
  ctr_e      predCtr;

  bht_datapath #(.ADDR_W(ADDR_W), .IDX_BITS(IDX_BITS)) dp_i (
    .clk(clk), .rst(rst), .predAddr(predAddr), .updAddr(updAddr),
    .strb(strb), .predHit(predHit), .predCtr(predCtr), .updHit(updHit)
  );

  bht_ctrl ctrl_i (
    .updValid(updValid), .updTaken(updTaken), .updHit(updHit),
    .predHit(predHit), .predCtr(predCtr), .strb(strb), .predTaken(predTaken)
  );

endmodule

// File: rtl/tagged_bht_chk.sv
module tagged_bht_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] predAddr,
  input logic              predTaken,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic              updTaken,
  input logic              updHit
);

  // first cycle out of reset: nothing is valid
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !predTaken);

  // a slot just written by an address must hit for that address
  assert_refill_hit_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(updValid) && !$past(rst) && updValid && updAddr == $past(updAddr)) |-> updHit);

  // fresh owner trained taken: 01 -> 10, predicted taken
  assert_alloc_taken_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(updValid && !updHit && updTaken) && !$past(rst) && predAddr == $past(updAddr))
      |-> predTaken);

  // fresh owner trained not taken: 01 -> 00, predicted not taken
  assert_alloc_nottaken_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(updValid && !updHit && !updTaken) && !$past(rst) && predAddr == $past(updAddr))
      |-> !predTaken);

  // no training strobe, same lookup address: same answer
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(updValid) && !$past(rst) && predAddr == $past(predAddr)) |-> $stable(predTaken));

endmodule

bind tagged_bht tagged_bht_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .predAddr(predAddr), .predTaken(predTaken),
  .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken), .updHit(updHit)
);

// File: tb/tagged_bht_tb_top.sv
`timescale 1ns/1ps
module tagged_bht_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] predAddr = '0;
  logic        predTaken;
  logic        updValid = 1'b0;
  logic [31:0] updAddr = '0;
  logic        updTaken = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tagged_bht #(.ADDR_W(32), .IDX_BITS(4)) dut_i (
    .clk(clk), .rst(rst), .predAddr(predAddr), .predTaken(predTaken),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: predTaken=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic train(input logic [31:0] a, input logic t);
    @(negedge clk);
    updValid = 1'b1; updAddr = a; updTaken = t;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic expectPred(input logic [31:0] a, input logic exp, input string req);
    predAddr = a;
    #1;
    check(predTaken, exp, req);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_R1();
    doReset();
    expectPred(32'h0000_0000, 1'b0, "R1");
    expectPred(32'h1234_5675, 1'b0, "R1");
    expectPred(32'hFFFF_FFFF, 1'b0, "R1");
  endtask

  task automatic t_alloc_R7();
    train(32'h0000_1003, 1'b1);           // 01 -> 10
    expectPred(32'h0000_1003, 1'b1, "R7 taken alloc");
    train(32'h0000_2004, 1'b0);           // 01 -> 00
    expectPred(32'h0000_2004, 1'b0, "R7 nottaken alloc");
    train(32'h0000_2004, 1'b1);           // 00 -> 01
    expectPred(32'h0000_2004, 1'b0, "R4 counter 01");
    train(32'h0000_2004, 1'b1);           // 01 -> 10
    expectPred(32'h0000_2004, 1'b1, "R5 counter 10");
  endtask

  task automatic t_saturate_R5_R6();
    for (int i = 0; i < 5; i++) train(32'h0000_3007, 1'b1);
    train(32'h0000_3007, 1'b0);           // 11 -> 10
    expectPred(32'h0000_3007, 1'b1, "R5 saturate high");
    train(32'h0000_3007, 1'b0);           // 10 -> 01
    expectPred(32'h0000_3007, 1'b0, "R6 step down");
    for (int i = 0; i < 5; i++) train(32'h0000_3007, 1'b0);
    train(32'h0000_3007, 1'b1);           // 00 -> 01
    expectPred(32'h0000_3007, 1'b0, "R6 saturate low");
  endtask

  task automatic t_alias_R2_R3();
    train(32'h0000_0100, 1'b1);
    train(32'h0000_0100, 1'b1);
    train(32'h0000_0100, 1'b1);           // strong taken
    expectPred(32'h0000_0100, 1'b1, "R4 owner taken");
    expectPred(32'h0000_0200, 1'b0, "R3 same slot other tag");
    expectPred(32'h8000_0100, 1'b0, "R3 upper bit differs");
    train(32'h0000_0200, 1'b0);           // steal slot 0: 00
    expectPred(32'h0000_0100, 1'b0, "R2 evicted owner");
    expectPred(32'h0000_0200, 1'b0, "R7 new owner");
    train(32'h0000_0100, 1'b0);           // reclaim: 01 -> 00
    train(32'h0000_0100, 1'b1);           // 00 -> 01, old 11 must be gone
    expectPred(32'h0000_0100, 1'b0, "R7 counter restarted");
    expectPred(32'h0000_0200, 1'b0, "R2 second eviction");
  endtask

  task automatic t_isolation_R8();
    train(32'h0000_0005, 1'b1);
    train(32'h0000_0005, 1'b1);
    for (int i = 0; i < 4; i++) train(32'h0000_0006 + 32'(i*16), 1'b0);
    expectPred(32'h0000_0005, 1'b1, "R8 neighbour kept");
    expectPred(32'h0000_0036, 1'b0, "R8 trained slot");
  endtask

  task automatic t_idle_R10();
    train(32'h0000_4009, 1'b1);           // 10
    train(32'h0000_4009, 1'b0);           // 01
    @(negedge clk);
    updValid = 1'b0; updAddr = 32'h0000_4009; updTaken = 1'b1;
    repeat (3) @(negedge clk);
    expectPred(32'h0000_4009, 1'b0, "R10 strobe low ignored");
    updAddr = 32'h0000_500A;
    repeat (2) @(negedge clk);
    expectPred(32'h0000_500A, 1'b0, "R10 no allocation");
  endtask

  task automatic t_same_cycle_R9();
    @(negedge clk);
    predAddr = 32'h0000_600B;
    updValid = 1'b1; updAddr = 32'h0000_600B; updTaken = 1'b1;
    #1;
    check(predTaken, 1'b0, "R9 before edge");
    @(negedge clk);
    updValid = 1'b0;
    #1;
    check(predTaken, 1'b1, "R9 after edge");
  endtask

  task automatic t_reset_priority_R11();
    @(negedge clk);
    rst = 1'b1;
    updValid = 1'b1; updAddr = 32'h0000_700C; updTaken = 1'b1;
    @(negedge clk);
    rst = 1'b0; updValid = 1'b0;
    expectPred(32'h0000_700C, 1'b0, "R11 training dropped");
    expectPred(32'h0000_0005, 1'b0, "R11 old entry cleared");
    expectPred(32'h0000_600B, 1'b0, "R1 cleared by reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_R1();
    t_alloc_R7();
    t_saturate_R5_R6();
    t_alias_R2_R3();
    t_isolation_R8();
    t_idle_R10();
    t_same_cycle_R9();
    t_reset_priority_R11();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule